// File: doc/BRIEF.md
# Stop-Mode Wake and Clock-Restart Sequencer

This block is the power-management controller of a small microcontroller. Software asks it to stop, and it gates the oscillator and every internal clock domain. It wakes the device for one of three reasons: an interrupt request, an active-low reset pin, or a change on the hardware-standby pin. On a wake it turns the oscillator back on and waits a programmable number of slow reference ticks. It then switches the four clock domains back on one per tick, in a fixed order. Last, it gives the CPU a resume code that says which way execution continues.

The stabilization wait comes from a register that software writes. The count runs on a free-running reference tick, which the block receives as a one-cycle enable. After power-on reset all clock domains run during the wait so that internal state can initialize. After any other wake they stay off until the ordered restart.

Top module: `stop_wake_seq`

## Requirements
- R1: After synchronous reset (power-on), `osc_en`=1, `int_reset`=1, `resume_mode`=0 and all four `clk_en` bits read 1 through the wait and the restart. The wait uses the register's reset value. At the end, `resume_mode` becomes 3 and `int_reset` drops to 0.
- R2: A `stop_req` pulse in the running state with `irq_req`=0 makes `stopped`=1, `osc_en`=0 and `clk_en`=0 from the next cycle. No reference ticks move the block out of stop.
- R3: A `stop_req` pulse while `irq_req`=1 is ignored: `stopped` stays 0 and all clock enables stay 1.
- R4: On a wake from stop, `osc_en` reads 1 from the next cycle. The wait then lasts N+1 reference ticks, where N is the value last written through `stab_we`/`stab_val`. Outside power-on, all `clk_en` bits stay 0 during that wait.
- R5: After the wait, the clock enables come on one per reference tick, in bit order: bit 0 peripheral, bit 1 DMA, bit 2 bus, bit 3 CPU. `restart_done` is high for exactly one cycle, the first cycle in which bit 3 reads 1.
- R6: An `irq_req` wake with `irq_allowed`=1, sampled at the wake, ends with `resume_mode`=1 (take the interrupt vector).
- R7: An `irq_req` wake with `irq_allowed`=0 ends with `resume_mode`=2 (continue at the next instruction).
- R8: `reset_n_pin`=0 while stopped, with `standby_pin`=1, sets `int_reset`=1 from the next cycle until the restart ends. The block then gives `resume_mode`=3 (reset vector).
- R9: While `standby_pin`=0, a low `reset_n_pin` has no effect. `int_reset` stays 0 and the block stays stopped.
- R10: A falling `standby_pin` while stopped brings `osc_en` to 1 at once. After the N+1 tick wait, with clocks off, the block returns to stop without any resume code.
- R11: A rising `standby_pin` in any state after power-on starts the reset sequence of R8 and ends with `resume_mode`=3.
- R12: A nonzero `resume_mode` holds its value until a one-cycle `resume_ack`, after which it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | One-cycle pulse of the slow reference tick |
| stab_we | input | 1 | Write strobe for the stabilization count |
| stab_val | input | STAB_W | Stabilization count to store |
| stop_req | input | 1 | Software stop request pulse |
| irq_req | input | 1 | Interrupt request pending |
| irq_allowed | input | 1 | Pending level is permitted by the mask and I flag |
| reset_n_pin | input | 1 | Active-low external reset pin |
| standby_pin | input | 1 | Hardware-standby pin |
| resume_ack | input | 1 | CPU has taken the resume code |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 4 | Clock enables: bit0 peripheral, bit1 DMA, bit2 bus, bit3 CPU |
| int_reset | output | 1 | Internal reset |
| resume_mode | output | 2 | 0 none, 1 interrupt vector, 2 next instruction, 3 reset vector |
| restart_done | output | 1 | One-cycle pulse when the CPU clock returns |
| stopped | output | 1 | Block is in stop |

## Verification
The bench builds the block with a 4-bit stabilization count and a reset value of 2. This keeps each wake sequence to a handful of ticks. It sweeps the count from 0 to 5 against both interrupt-mask outcomes, so each enable bit's tick position can be computed as the count plus a step index. Reset-pin, standby-fall and standby-rise wakes each use a short count of their own. The standby-fall wake holds the reset pin low at the same time, which tests the masking of the reset pin.

// File: rtl/swk_pkg.sv
package swk_pkg;

    localparam int NUM_DOM = 4;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WAIT = 2'd2,
        ST_RAMP = 2'd3
    } pm_state_e;

    typedef enum logic [1:0] {
        WK_POR = 2'd0,
        WK_IRQ = 2'd1,
        WK_PIN = 2'd2,
        WK_SBY = 2'd3
    } wake_src_e;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_IRQV = 2'd1,
        RES_NEXT = 2'd2,
        RES_RSTV = 2'd3
    } resume_e;

    function automatic resume_e pick_resume(wake_src_e src, logic irq_ok);
        case (src)
            WK_IRQ:  return irq_ok ? RES_IRQV : RES_NEXT;
            WK_SBY:  return RES_NONE;
            default: return RES_RSTV;
        endcase
    endfunction

endpackage

// File: rtl/swk_stab_timer.sv
module swk_stab_timer #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  logic [W-1:0] cfg_val,
    input  logic         load,
    input  logic         run,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] limit_q;
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= RST_VAL;
        end else if (cfg_we) begin
            limit_q <= cfg_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= limit_q;
        end else if (run && tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run && tick && (cnt_q == '0);

    assert_count_down_only_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && !$past(rst)) |-> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/swk_clk_ramp.sv
module swk_clk_ramp #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic         tick,
    output logic [N-1:0] en,
    output logic         last
);
    localparam int SW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  en_q;
    logic [SW-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            en_q   <= '0;
            step_q <= '0;
        end else if (run && tick) begin
            en_q[step_q] <= 1'b1;
            step_q       <= step_q + 1'b1;
        end
    end

    assign en   = en_q;
    assign last = run && tick && (step_q == SW'(N - 1));

    for (genvar k = 1; k < N; k++) begin : g_order
        assert_domain_order_R5: assert property (@(posedge clk) disable iff (rst)
            (en_q[k] && !$past(en_q[k])) |-> $past(en_q[k-1]));
    end

endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
    import swk_pkg::*;
#(
    parameter int               STAB_W   = 16,
    parameter logic [STAB_W-1:0] STAB_RST = STAB_W'(255)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              stab_we,
    input  logic [STAB_W-1:0] stab_val,
    input  logic              stop_req,
    input  logic              irq_req,
    input  logic              irq_allowed,
    input  logic              reset_n_pin,
    input  logic              standby_pin,
    input  logic              resume_ack,
    output logic              osc_en,
    output logic [3:0]        clk_en,
    output logic              int_reset,
    output logic [1:0]        resume_mode,
    output logic              restart_done,
    output logic              stopped
);
    pm_state_e    state_q;
    wake_src_e    src_q;
    resume_e      res_q;
    logic         por_q, irst_q, irq_ok_q, done_q, sby_q;
    logic         sby_rise, sby_fall, hard_wake, pin_wake;
    logic         go_wait, go_stop, expire, ramp_last;
    logic [NUM_DOM-1:0] ramp_en;

    assign sby_rise  = standby_pin && !sby_q;
    assign sby_fall  = !standby_pin && sby_q;
    assign hard_wake = sby_rise && !por_q;
    assign pin_wake  = !reset_n_pin && standby_pin;

    assign go_wait = hard_wake ||
                     (state_q == ST_STOP && (sby_fall || pin_wake || irq_req));
    assign go_stop = !hard_wake && state_q == ST_RUN && stop_req && !irq_req;

    swk_stab_timer #(.W(STAB_W), .RST_VAL(STAB_RST)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (stab_we),
        .cfg_val (stab_val),
        .load    (go_wait),
        .run     (state_q == ST_WAIT),
        .tick    (tick),
        .expire  (expire)
    );

    swk_clk_ramp #(.N(NUM_DOM)) u_ramp (
        .clk   (clk),
        .rst   (rst),
        .clear (go_wait || go_stop),
        .run   (state_q == ST_RAMP),
        .tick  (tick),
        .en    (ramp_en),
        .last  (ramp_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_WAIT;
            src_q    <= WK_POR;
            res_q    <= RES_NONE;
            por_q    <= 1'b1;
            irst_q   <= 1'b1;
            irq_ok_q <= 1'b0;
            done_q   <= 1'b0;
            sby_q    <= 1'b1;
        end else begin
            sby_q  <= standby_pin;
            done_q <= 1'b0;
            if (resume_ack) res_q <= RES_NONE;
            if (hard_wake) begin
                state_q <= ST_WAIT;
                src_q   <= WK_PIN;
                irst_q  <= 1'b1;
            end else begin
                case (state_q)
                    ST_RUN: if (go_stop) state_q <= ST_STOP;
                    ST_STOP: begin
                        if (sby_fall) begin
                            state_q <= ST_WAIT;
                            src_q   <= WK_SBY;
                        end else if (pin_wake) begin
                            state_q <= ST_WAIT;
                            src_q   <= WK_PIN;
                            irst_q  <= 1'b1;
                        end else if (irq_req) begin
                            state_q  <= ST_WAIT;
                            src_q    <= WK_IRQ;
                            irq_ok_q <= irq_allowed;
                        end
                    end
                    ST_WAIT: if (expire) state_q <= (src_q == WK_SBY) ? ST_STOP : ST_RAMP;
                    ST_RAMP: if (ramp_last) begin
                        state_q <= ST_RUN;
                        done_q  <= 1'b1;
                        res_q   <= pick_resume(src_q, irq_ok_q);
                        irst_q  <= 1'b0;
                        por_q   <= 1'b0;
                    end
                    default: state_q <= ST_RUN;
                endcase
            end
        end
    end

    assign osc_en       = (state_q != ST_STOP);
    assign clk_en       = por_q ? '1 : ramp_en;
    assign int_reset    = irst_q;
    assign resume_mode  = res_q;
    assign restart_done = done_q;
    assign stopped      = (state_q == ST_STOP);

    assert_stop_gated_R2: assert property (@(posedge clk) disable iff (rst)
        stopped |-> (!osc_en && clk_en == '0));

    assert_stop_blocked_R3: assert property (@(posedge clk) disable iff (rst)
        (!stopped && stop_req && irq_req) |=> !stopped);

    assert_wait_dark_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !por_q) |-> (clk_en == '0));

    assert_done_full_R5: assert property (@(posedge clk) disable iff (rst)
        restart_done |-> (clk_en == '1 && $past(state_q == ST_RAMP)));

    assert_pin_masked_R9: assert property (@(posedge clk) disable iff (rst)
        (stopped && !standby_pin && !sby_q && !irq_req) |=> (stopped && !int_reset));

    assert_resume_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (res_q != RES_NONE && !resume_ack && state_q != ST_RAMP) |=> $stable(res_q));

endmodule

// File: tb/stop_wake_seq_test.sv
module stop_wake_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 4;
    localparam logic [SW-1:0] SRST = 4'd2;

    logic          clk = 1'b0;
    logic          rst, tick, stab_we, stop_req, irq_req, irq_allowed;
    logic          reset_n_pin, standby_pin, resume_ack;
    logic [SW-1:0] stab_val;
    logic          osc_en, int_reset, restart_done, stopped;
    logic [3:0]    clk_en;
    logic [1:0]    resume_mode;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stop_wake_seq #(.STAB_W(SW), .STAB_RST(SRST)) uut (
        .clk(clk), .rst(rst), .tick(tick), .stab_we(stab_we), .stab_val(stab_val),
        .stop_req(stop_req), .irq_req(irq_req), .irq_allowed(irq_allowed),
        .reset_n_pin(reset_n_pin), .standby_pin(standby_pin), .resume_ack(resume_ack),
        .osc_en(osc_en), .clk_en(clk_en), .int_reset(int_reset),
        .resume_mode(resume_mode), .restart_done(restart_done), .stopped(stopped)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    task automatic set_stab(input int n);
        stab_val = SW'(n);
        stab_we  = 1'b1;
        cyc();
        stab_we  = 1'b0;
    endtask

    task automatic enter_stop();
        stop_req = 1'b1;
        cyc();
        stop_req = 1'b0;
        check("R2", "stopped", stopped, 1);
        check("R2", "osc_en", osc_en, 0);
        check("R2", "clk_en", clk_en, 0);
        for (int i = 0; i < 3; i++) pulse_tick();
        check("R2", "stays stopped", stopped, 1);
    endtask

    // n+1 wait ticks with clocks off, then one enable bit per tick
    task automatic wake_seq(input int n, input int code, input bit rexp, input string req);
        for (int i = 1; i <= n + 5; i++) begin
            int k;
            int m;
            pulse_tick();
            k = i - (n + 1);
            m = (k <= 0) ? 0 : ((1 << k) - 1);
            check((k <= 0) ? "R4" : "R5", "clk_en", clk_en, m);
            check("R4", "osc_en", osc_en, 1);
            check("R5", "restart_done", restart_done, (i == n + 5) ? 1 : 0);
            check(req, "int_reset", int_reset, (i == n + 5) ? 0 : rexp);
        end
        check(req, "resume_mode", resume_mode, code);
        cyc();
        check("R5", "done one cycle", restart_done, 0);
        cyc();
        cyc();
        check("R12", "resume held", resume_mode, code);
        resume_ack = 1'b1;
        cyc();
        resume_ack = 1'b0;
        check("R12", "resume cleared", resume_mode, 0);
    endtask

    initial begin
        rst = 1'b1; tick = 1'b0; stab_we = 1'b0; stab_val = '0; stop_req = 1'b0;
        irq_req = 1'b0; irq_allowed = 1'b0; reset_n_pin = 1'b1; standby_pin = 1'b1;
        resume_ack = 1'b0;
        cyc(); cyc();
        rst = 1'b0;
        // R1 power-on state and sequence
        check("R1", "osc_en", osc_en, 1);
        check("R1", "int_reset", int_reset, 1);
        check("R1", "clk_en", clk_en, 4'hF);
        check("R1", "resume_mode", resume_mode, 0);
        for (int i = 1; i <= int'(SRST) + 5; i++) begin
            pulse_tick();
            check("R1", "clk_en por", clk_en, 4'hF);
        end
        check("R1", "resume_mode end", resume_mode, 3);
        check("R1", "int_reset end", int_reset, 0);
        check("R1", "restart_done", restart_done, 1);
        resume_ack = 1'b1; cyc(); resume_ack = 1'b0;

        // R3 stop ignored with pending interrupt
        irq_req = 1'b1; stop_req = 1'b1;
        cyc();
        stop_req = 1'b0; irq_req = 1'b0;
        check("R3", "stopped", stopped, 0);
        check("R3", "clk_en", clk_en, 4'hF);

        // R6 / R7 interrupt wakes over a sweep of counts
        for (int n = 0; n <= 5; n++) begin
            for (int a = 0; a <= 1; a++) begin
                set_stab(n);
                enter_stop();
                irq_req = 1'b1; irq_allowed = a[0];
                cyc();
                irq_req = 1'b0; irq_allowed = ~a[0];
                check("R4", "osc_en at wake", osc_en, 1);
                check("R4", "clk_en at wake", clk_en, 0);
                wake_seq(n, a ? 1 : 2, 1'b0, a ? "R6" : "R7");
            end
        end

        // R8 reset pin wake
        set_stab(3);
        enter_stop();
        reset_n_pin = 1'b0;
        cyc();
        reset_n_pin = 1'b1;
        check("R8", "int_reset at wake", int_reset, 1);
        wake_seq(3, 3, 1'b1, "R8");

        // R10 standby fall with R9 reset pin held low
        set_stab(2);
        enter_stop();
        standby_pin = 1'b0; reset_n_pin = 1'b0;
        cyc();
        check("R10", "osc_en at fall", osc_en, 1);
        check("R9", "int_reset", int_reset, 0);
        for (int i = 1; i <= 3; i++) begin
            pulse_tick();
            check("R10", "clk_en", clk_en, 0);
        end
        check("R10", "back in stop", stopped, 1);
        check("R10", "osc_en off", osc_en, 0);
        check("R10", "no resume", resume_mode, 0);
        for (int i = 0; i < 4; i++) pulse_tick();
        check("R9", "still stopped", stopped, 1);
        check("R9", "no reset", int_reset, 0);
        reset_n_pin = 1'b1;
        cyc();
        standby_pin = 1'b1;
        cyc();
        check("R11", "int_reset on rise", int_reset, 1);
        wake_seq(2, 3, 1'b1, "R11");

        // R11 standby rise while running
        standby_pin = 1'b0;
        cyc(); cyc();
        check("R11", "fall in run ignored", clk_en, 4'hF);
        standby_pin = 1'b1;
        cyc();
        check("R11", "int_reset run rise", int_reset, 1);
        check("R11", "clk_en off", clk_en, 0);
        wake_seq(2, 3, 1'b1, "R11");

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule